// File: doc/BRIEF.md
# External Interrupt Request Flag Register

This block keeps one pending-request flag for each of eight external interrupt pins. The flags occupy the upper byte of a 16-bit bus word. A qualified per-pin event sets a flag. While the system is halted in stop state, a high level on a pin also sets that pin's flag. Software sees which pins are pending by reading the word. The lower byte always reads as zero.

Software clears flags by writing zeros. A one written to a flag position leaves that flag as it was. The read phase of a read-modify-write returns ones in every flag position. The write-back that follows therefore clears only the bits that software explicitly zeroed, and a request that arrives between the read and the write survives.

An 8-bit enable mask gates the flags onto one interrupt line toward the interrupt controller. Event qualification happens upstream and arrives as a one-cycle detect pulse per pin. The pin levels used for the stop-state path pass through a two-stage synchronizer.

Top module: `ext_irq_flag_reg`

## Requirements
- R1: After reset all eight flags are 0, a read of the register returns 16'h0000 and irq is 0.
- R2: A detect pulse on bit n of `evt_det` in a clock cycle sets flag n at that clock edge, and the flag reads back as 1 from the next cycle on.
- R3: With `bus_rd` high, `bus_rmw` low and `bus_addr` equal to the register address, `bus_rdata` shows flag n at bit 8+n and 0 in bits 7:0. In every other case `bus_rdata` is 16'h0000.
- R4: A write to the register with the upper strobe `bus_strb[1]` high clears every flag n whose data bit `bus_wdata[8+n]` is 0, from the following cycle on.
- R5: A write with `bus_wdata[8+n]` equal to 1 leaves flag n unchanged.
- R6: A write that has `bus_strb[1]` low, or that targets another address, changes no flag.
- R7: A read with `bus_rmw` high at the register address returns 16'hFF00, whatever the flags are.
- R8: While `stop_req` is high, a high level on `pin_lvl[n]` sets flag n. After the pin rises, the flag is set at the third clock edge (two synchronizer stages and then the flag register). With `stop_req` low, the pin level alone sets nothing.
- R9: When a set event and a write-zero clear hit the same flag in the same cycle, the flag ends up as 1.
- R10: `irq` is 1 exactly when some flag n is 1 while `irq_en[n]` is 1, and it follows the flags and the mask without added delay.
- R11: Driving `rst_n` low at any time clears all flags at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Word address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks a read as the read phase of a read-modify-write |
| bus_wdata | input | 16 | Write data; zeros in bits 15:8 clear flags |
| bus_strb | input | 2 | Byte-lane strobes; bit 1 covers bits 15:8 |
| bus_rdata | output | 16 | Read data, combinational |
| evt_det | input | 8 | One-cycle qualified event per pin |
| pin_lvl | input | 8 | Raw pin levels, synchronized inside |
| stop_req | input | 1 | High while the system is in stop state |
| irq_en | input | 8 | Per-flag enable mask toward irq |
| irq | output | 1 | Any enabled flag pending |

## Verification
Read data and irq are combinational from the flag register, so they are due in the same cycle as the read or mask change. Detect pulses and write clears show up one edge later, and a pin level in stop state shows up at the third edge. The bench drives inputs 2 ns after a rising edge and samples 1 ns or 2 ns later. A reference model, advanced on the same edges, is compared at every falling edge. The directed checks read the stop-state flag after edges one, two and three to pin down that latency.

// File: rtl/eif_pkg.sv
`timescale 1ns/1ps
package eif_pkg;

  // decoded view of one bus cycle, shared between the bus port and the top
  typedef struct packed {
    logic hit;      // address matches the register
    logic rd;       // plain read
    logic rd_all;   // read phase of a read-modify-write
    logic wr_up;    // write that reaches the flag byte lane
  } eif_bus_t;

endpackage

// File: rtl/eif_rst_sync.sv
`timescale 1ns/1ps
module eif_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/eif_pin_sync.sv
`timescale 1ns/1ps
module eif_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] pin_sync
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_pin
      logic [STAGES-1:0] stg_q;
      logic [STAGES-1:0] stg_d;

      always_comb begin
        stg_d = {stg_q[STAGES-2:0], pin_raw[g]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
      end

      assign pin_sync[g] = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/eif_bus_port.sv
`timescale 1ns/1ps
module eif_bus_port
  import eif_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 16,
  parameter int              NUM_FLAGS = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic                rd,
  input  logic                rmw,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] strb,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] clr_vec,
  output logic [DATA_W-1:0]   rdata,
  output eif_bus_t            dec
);

  localparam int STRB_W   = DATA_W / 8;
  localparam int FLAG_LSB = DATA_W - NUM_FLAGS;

  always_comb begin
    dec.hit    = (addr == REG_ADDR);
    dec.rd     = dec.hit && rd && !rmw;
    dec.rd_all = dec.hit && rd && rmw;
    dec.wr_up  = dec.hit && wr && strb[STRB_W-1];
  end

  // a zero in a flag position of an accepted write requests a clear
  always_comb begin
    clr_vec = '0;
    if (dec.wr_up) clr_vec = ~wdata[DATA_W-1:FLAG_LSB];
  end

  always_comb begin
    rdata = '0;
    if (dec.rd_all)  rdata[DATA_W-1:FLAG_LSB] = '1;
    else if (dec.rd) rdata[DATA_W-1:FLAG_LSB] = flags;
  end

endmodule

// File: rtl/eif_flag_bank.sv
`timescale 1ns/1ps
module eif_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] en_mask,
  output logic [N-1:0] flags,
  output logic         irq
);

  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;
  logic         upd_en;

  // set has priority over clear so that no request is lost
  always_comb begin
    upd_en  = (|set_vec) || (|clr_vec);
    flags_d = (flags_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & en_mask);

  // R2 / R9: every set request is present after the edge, even under a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  // R4: a cleared bit without a concurrent set reads 0 afterwards
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((flags_q & $past(clr_vec & ~set_vec)) == '0));

  // R5: a flag only falls where a clear was requested
  a_r5_no_stray_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((~flags_q & $past(flags_q)) & ~$past(clr_vec)) == '0));

endmodule

// File: rtl/ext_irq_flag_reg.sv
`timescale 1ns/1ps
module ext_irq_flag_reg
  import eif_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 16,
  parameter int                NUM_PINS  = 8,
  parameter int                SYNC_LEN  = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                bus_rmw,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W/8-1:0] bus_strb,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] evt_det,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic                stop_req,
  input  logic [NUM_PINS-1:0] irq_en,
  output logic                irq
);

  localparam int STRB_W = DATA_W / 8;

  logic                rst_int_n;
  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] flags_q;
  logic [NUM_PINS-1:0] clr_vec;
  logic [NUM_PINS-1:0] set_vec;
  eif_bus_t            dec;

  eif_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  eif_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_LEN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pin_raw  (pin_lvl),
    .pin_sync (pin_s)
  );

  eif_bus_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_FLAGS(NUM_PINS), .REG_ADDR(REG_ADDR)
  ) u_bus (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .rmw     (bus_rmw),
    .wdata   (bus_wdata),
    .strb    (bus_strb),
    .flags   (flags_q),
    .clr_vec (clr_vec),
    .rdata   (bus_rdata),
    .dec     (dec)
  );

  // stop state turns a synchronized high level into a set request
  always_comb begin
    set_vec = evt_det | (pin_s & {NUM_PINS{stop_req}});
  end

  eif_flag_bank #(.N(NUM_PINS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .en_mask (irq_en),
    .flags   (flags_q),
    .irq     (irq)
  );

  // R6: a flag can only fall after an accepted upper-lane write to the register
  a_r6_ignored_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(bus_wr && (bus_addr == REG_ADDR) && bus_strb[STRB_W-1])
      |=> ((~flags_q & $past(flags_q)) == '0));

  // R8: a synchronized high pin in stop state shows as a set flag one edge later
  a_r8_stop_level: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stop_req && (|pin_s)) |=> (($past(pin_s) & ~flags_q) == '0));

  // R7: the read-modify-write read never reports a cleared flag position
  a_r7_rmw_ones: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dec.rd_all) |-> (bus_rdata[DATA_W-1 -: NUM_PINS] == '1));

endmodule

// File: tb/sim_ext_irq_flag_reg.sv
`timescale 1ns/1ps
module sim_ext_irq_flag_reg;

  localparam logic [7:0] RA = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_rmw = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_strb = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  evt_det = '0, pin_lvl = '0, irq_en = '0;
  logic        stop_req = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  ext_irq_flag_reg u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rmw(bus_rmw), .bus_wdata(bus_wdata),
    .bus_strb(bus_strb), .bus_rdata(bus_rdata), .evt_det(evt_det),
    .pin_lvl(pin_lvl), .stop_req(stop_req), .irq_en(irq_en), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  bit [7:0] m_flags;
  bit [7:0] m_pipe[$];   // pin levels in flight through the synchronizer
  int       m_wait;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = 0; m_pipe = {8'h00, 8'h00}; m_wait = 0;
    end else if (m_wait < 2) begin
      m_wait++;
    end else begin
      bit [7:0] setm, clrm;
      setm = evt_det | (stop_req ? m_pipe[0] : 8'h00);
      clrm = (bus_wr && bus_addr == RA && bus_strb[1]) ? ~bus_wdata[15:8] : 8'h00;
      m_flags = (m_flags & ~clrm) | setm;
      void'(m_pipe.pop_front());
      m_pipe.push_back(pin_lvl);
    end
  end

  function automatic logic [15:0] m_rdata();
    if (!(bus_rd && bus_addr == RA)) return 16'h0000;
    if (bus_rmw) return 16'hFF00;
    return {m_flags, 8'h00};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (bus_rdata !== m_rdata() || irq !== |(m_flags & irq_en)) begin
        failures++;
        $display("FAIL %s model: rdata=%h irq=%b expected rdata=%h irq=%b",
                 cur_req, bus_rdata, irq, m_rdata(), |(m_flags & irq_en));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle_bus();
    bus_wr = 0; bus_rd = 0; bus_rmw = 0; bus_strb = 0; bus_wdata = 0; bus_addr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic m, output logic [15:0] v);
    step(); idle_bus(); bus_rd = 1; bus_addr = a; bus_rmw = m; #1 v = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] s);
    step(); idle_bus(); bus_wr = 1; bus_addr = a; bus_wdata = d; bus_strb = s;
    step(); idle_bus();
  endtask

  task automatic pulse(input logic [7:0] v);
    step(); evt_det = v; step(); evt_det = 0;
  endtask

  logic [15:0] v;

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) step();

    cur_req = "R1";
    rd(RA, 0, v); chk("R1 flags after reset", v, 16'h0000);
    chk("R1 irq after reset", {15'b0, irq}, 16'h0000);

    cur_req = "R2";
    pulse(8'h48);
    rd(RA, 0, v); chk("R2 detect sets flags 3,6", v, 16'h4800);

    cur_req = "R3";
    rd(8'h41, 0, v); chk("R3 other address reads 0", v, 16'h0000);
    step(); idle_bus(); #1 chk("R3 no read gives 0", bus_rdata, 16'h0000);

    cur_req = "R10";
    irq_en = 8'h08; #1 chk("R10 enabled flag 3 raises irq", {15'b0, irq}, 16'h0001);
    irq_en = 8'h80; #1 chk("R10 masked flags give no irq", {15'b0, irq}, 16'h0000);
    irq_en = 8'hFF;

    cur_req = "R7";
    rd(RA, 1, v); chk("R7 rmw read all ones", v, 16'hFF00);

    cur_req = "R4";
    wr(RA, 16'hF7FF, 2'b10);
    rd(RA, 0, v); chk("R4 zero clears flag 3, R5 ones keep flag 6", v, 16'h4000);

    cur_req = "R6";
    wr(RA, 16'h0000, 2'b01);
    rd(RA, 0, v); chk("R6 lower-lane write ignored", v, 16'h4000);
    wr(8'h42, 16'h0000, 2'b11);
    rd(RA, 0, v); chk("R6 other-address write ignored", v, 16'h4000);

    cur_req = "R5";
    pulse(8'hFF);
    wr(RA, 16'h55AA, 2'b11);
    rd(RA, 0, v); chk("R5 pattern write keeps ones", v, 16'h5500);

    cur_req = "R9";
    step(); idle_bus(); bus_wr = 1; bus_addr = RA; bus_wdata = 16'h0000; bus_strb = 2'b10;
    evt_det = 8'h01;
    step(); idle_bus(); evt_det = 0;
    rd(RA, 0, v); chk("R9 set beats clear", v, 16'h0100);

    cur_req = "R8";
    wr(RA, 16'h0000, 2'b10);
    pin_lvl = 8'h0F;
    repeat (5) step();
    rd(RA, 0, v); chk("R8 pin level ignored outside stop", v, 16'h0000);
    pin_lvl = 8'h00;
    repeat (4) step();
    stop_req = 1; pin_lvl = 8'h30;
    @(posedge clk); #1 chk("R8 not set after edge 1", bus_rdata, 16'h0000);
    @(posedge clk); #1 chk("R8 not set after edge 2", bus_rdata, 16'h0000);
    @(posedge clk); #1 chk("R8 set after edge 3", bus_rdata, 16'h3000);
    #1 pin_lvl = 8'h00;
    repeat (4) step();
    stop_req = 0;
    rd(RA, 0, v); chk("R8 flag held after pin drops", v, 16'h3000);

    cur_req = "R11";
    #1 rst_n = 0;
    #1 chk("R11 async reset clears flags", {15'b0, irq}, 16'h0000);
    step(); rst_n = 1;
    repeat (4) step();
    rd(RA, 0, v); chk("R11 flags zero after reset", v, 16'h0000);

    step(); idle_bus();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule